// File: doc/BRIEF.md
# Multicycle Instruction Control Sequencer

This block is the control unit of a small non-pipelined processor with 16-bit words. It keeps track of which cycle of the current instruction is running. From that cycle and the decoded instruction class it drives every datapath strobe: the PC write and its source, the operation of the shared ALU, the memory address source, memory read and write, the instruction-register load, the register-file write and its source. Every instruction runs to completion before the next begins. There is no separate PC adder: the first cycle of nearly every instruction increments the PC through the ALU.

The fetch of the next opcode shares the last cycle of the current instruction, so no cycle is spent on fetch. The datapath presents the opcode field of the memory read data on `mem_op`. The sequencer decodes that value combinationally and captures the decoded class on the same rising edge that loads the instruction register, so the new instruction acts in the very next cycle. Logic and arithmetic operations, jumps and unknown opcodes take two cycles. Load, store and load-immediate take three, and load-immediate uses the word that follows its opcode as data.

Top module: `mcs_ctrl`

## Requirements
- R1: After a synchronous reset, one fetch-only cycle comes first: `mem_rd`=1, `ir_ld`=1, `addr_sel`=0 (address from the PC), `cyc`=0, with `pc_we`, `pc_sel`, `rf_we`, `mem_wr`, `wb_sel` at 0 and `alu_op`=0.
- R2: Opcodes 0x01 to 0x06 (add, subtract, and, or, xor, move) take 2 cycles. Cycle 0 writes the PC with `pc_sel`=0 and `alu_op`=0 (increment). Cycle 1 raises `rf_we` with `wb_sel`=0 (ALU result) and `alu_op` equal to the opcode's low three bits (1 add, 2 sub, 3 and, 4 or, 5 xor, 6 pass second operand).
- R3: Load (0x11) and store (0x12) take 3 cycles, with `addr_sel`=1 (register address) in cycle 1. Load raises `mem_rd` and `rf_we` with `wb_sel`=1. Store raises `mem_wr` only. `mem_rd` and `mem_wr` are never high together.
- R4: Load-immediate (0x10) takes 3 cycles. In cycle 1 it reads the word at the PC into the destination register (`mem_rd`, `rf_we`, `wb_sel`=1, `addr_sel`=0) and increments the PC again. That word is never decoded as an opcode, whatever its value.
- R5: Jump (0x20) takes 2 cycles. Cycle 0 loads the PC from a register (`pc_we`=1, `pc_sel`=1). The following fetch reads the jump target, not the word after the jump.
- R6: The fetch happens exactly in the last cycle of each instruction: `mem_rd`, `ir_ld` and `addr_sel`=0 together. The next cycle is cycle 0 of the fetched instruction and already acts on its opcode.
- R7: Any other opcode takes 2 cycles, increments the PC in cycle 0, and raises neither `rf_we` nor `mem_wr`.
- R8: The opcode is bits [15:10] of the memory word and is matched on all six bits, so near values such as 0x21, 0x30, 0x07 and 0x3F follow R7.
- R9: `cyc` counts 0, 1 (and 2 for three-cycle instructions) and returns to 0 after each fetch. No instruction runs longer than 3 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_op | input | 6 | Opcode field (bits 15:10) of the current memory read data |
| pc_we | output | 1 | Write the PC this cycle |
| pc_sel | output | 1 | PC source: 0 ALU result, 1 register operand |
| alu_op | output | 3 | ALU operation: 0 increment PC, 1 add, 2 sub, 3 and, 4 or, 5 xor, 6 pass |
| addr_sel | output | 1 | Memory address: 0 PC, 1 register operand |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_ld | output | 1 | Load the instruction register (fetch) |
| rf_we | output | 1 | Register-file write |
| wb_sel | output | 1 | Register write data: 0 ALU result, 1 memory data |
| cyc | output | 2 | Cycle index within the current instruction |

## Verification
A datapath and memory stub obeys the strobes and runs a program. The program starts with a directed prologue: every ALU operation, load-immediates whose data words look like store and jump opcodes, the near-miss unknown opcodes, a store and load pair, and a jump over words that would corrupt state if they ran. A seeded random mix of the same kinds follows. Each cycle's strobes are compared with the table implied by the instruction class and cycle index. This separates cycle-0 PC handling from cycle-1 work and the fetch. The length of every instruction and every fetch address are compared with an instruction-level model. A wrong length or a decoded immediate shows up as a shifted fetch address, and a dropped strobe shows up as a mismatch in the final register or data-memory contents.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    localparam int OP_W       = 6;
    localparam int MAX_LEN    = 3;
    localparam int CYC_W      = $clog2(MAX_LEN);
    localparam int LAST_SHORT = 1;
    localparam int LAST_LONG  = MAX_LEN - 1;

    localparam logic [OP_W-1:0] OP_ADD = 6'h01;
    localparam logic [OP_W-1:0] OP_SUB = 6'h02;
    localparam logic [OP_W-1:0] OP_AND = 6'h03;
    localparam logic [OP_W-1:0] OP_OR  = 6'h04;
    localparam logic [OP_W-1:0] OP_XOR = 6'h05;
    localparam logic [OP_W-1:0] OP_MOV = 6'h06;
    localparam logic [OP_W-1:0] OP_LDI = 6'h10;
    localparam logic [OP_W-1:0] OP_LD  = 6'h11;
    localparam logic [OP_W-1:0] OP_ST  = 6'h12;
    localparam logic [OP_W-1:0] OP_JMP = 6'h20;

    typedef enum logic [2:0] {
        CL_NOP, CL_ALU, CL_LDI, CL_LD, CL_ST, CL_JMP
    } cls_t;

    typedef enum logic [2:0] {
        AO_INC  = 3'd0,
        AO_ADD  = 3'd1,
        AO_SUB  = 3'd2,
        AO_AND  = 3'd3,
        AO_OR   = 3'd4,
        AO_XOR  = 3'd5,
        AO_PASS = 3'd6
    } alu_op_t;

    // decoded instruction, held for the whole instruction
    typedef struct packed {
        cls_t             cls;
        alu_op_t          aop;
        logic [CYC_W-1:0] last;
    } dec_t;

    // sequencer state
    typedef struct packed {
        logic             boot;
        logic [CYC_W-1:0] cyc;
        dec_t             dec;
    } seq_t;

    // control strobes
    typedef struct packed {
        logic    pc_we;
        logic    pc_sel;
        alu_op_t alu_op;
        logic    addr_sel;
        logic    mem_rd;
        logic    mem_wr;
        logic    ir_ld;
        logic    rf_we;
        logic    wb_sel;
    } ctl_t;

endpackage

// File: rtl/mcs_opdecode.sv
module mcs_opdecode
    import mcs_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output dec_t            dec
);

    // full-width match; anything unlisted becomes a two-cycle no-op
    always_comb begin
        dec.cls  = CL_NOP;
        dec.aop  = AO_INC;
        dec.last = CYC_W'(LAST_SHORT);
        case (op)
            OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_MOV: begin
                dec.cls = CL_ALU;
                dec.aop = alu_op_t'(op[2:0]);
            end
            OP_LDI: begin
                dec.cls  = CL_LDI;
                dec.last = CYC_W'(LAST_LONG);
            end
            OP_LD: begin
                dec.cls  = CL_LD;
                dec.last = CYC_W'(LAST_LONG);
            end
            OP_ST: begin
                dec.cls  = CL_ST;
                dec.last = CYC_W'(LAST_LONG);
            end
            OP_JMP: begin
                dec.cls = CL_JMP;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mcs_seq.sv
module mcs_seq
    import mcs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  dec_t fwd_dec,
    output seq_t st_q,
    output logic fetch
);

    localparam seq_t SEQ_RST = '{1'b1, {CYC_W{1'b0}},
                                 '{CL_NOP, AO_INC, {CYC_W{1'b0}}}};

    seq_t st_d;

    always_comb begin
        fetch = st_q.boot || (st_q.cyc == st_q.dec.last);
        st_d  = st_q;
        if (fetch) begin
            // the forwarded opcode's decode is captured with the IR load
            st_d.boot = 1'b0;
            st_d.cyc  = '0;
            st_d.dec  = fwd_dec;
        end else begin
            st_d.cyc = st_q.cyc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= SEQ_RST;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/mcs_strobe.sv
module mcs_strobe
    import mcs_pkg::*;
(
    input  seq_t st,
    input  logic fetch,
    output ctl_t ctl
);

    always_comb begin
        ctl        = '0;
        ctl.alu_op = AO_INC;
        if (fetch) begin
            ctl.mem_rd = 1'b1;
            ctl.ir_ld  = 1'b1;
        end
        if (!st.boot) begin
            if (st.cyc == '0) begin
                // first cycle: PC+1 through the ALU, or jump target
                ctl.pc_we  = 1'b1;
                ctl.pc_sel = (st.dec.cls == CL_JMP);
            end else if (st.cyc == CYC_W'(1)) begin
                case (st.dec.cls)
                    CL_ALU: begin
                        ctl.rf_we  = 1'b1;
                        ctl.wb_sel = 1'b0;
                        ctl.alu_op = st.dec.aop;
                    end
                    CL_LDI: begin
                        ctl.mem_rd = 1'b1;
                        ctl.rf_we  = 1'b1;
                        ctl.wb_sel = 1'b1;
                        ctl.pc_we  = 1'b1;
                        ctl.alu_op = AO_INC;
                    end
                    CL_LD: begin
                        ctl.mem_rd   = 1'b1;
                        ctl.addr_sel = 1'b1;
                        ctl.rf_we    = 1'b1;
                        ctl.wb_sel   = 1'b1;
                    end
                    CL_ST: begin
                        ctl.mem_wr   = 1'b1;
                        ctl.addr_sel = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/mcs_ctrl.sv
module mcs_ctrl
    import mcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OP_W-1:0]  mem_op,
    output logic             pc_we,
    output logic             pc_sel,
    output logic [2:0]       alu_op,
    output logic             addr_sel,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             ir_ld,
    output logic             rf_we,
    output logic             wb_sel,
    output logic [CYC_W-1:0] cyc
);

    dec_t fwd_dec;
    seq_t st_q;
    logic fetch;
    ctl_t ctl;

    mcs_opdecode u_dec (
        .op  (mem_op),
        .dec (fwd_dec)
    );

    mcs_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .fwd_dec (fwd_dec),
        .st_q    (st_q),
        .fetch   (fetch)
    );

    mcs_strobe u_stb (
        .st    (st_q),
        .fetch (fetch),
        .ctl   (ctl)
    );

    assign pc_we    = ctl.pc_we;
    assign pc_sel   = ctl.pc_sel;
    assign alu_op   = ctl.alu_op;
    assign addr_sel = ctl.addr_sel;
    assign mem_rd   = ctl.mem_rd;
    assign mem_wr   = ctl.mem_wr;
    assign ir_ld    = ctl.ir_ld;
    assign rf_we    = ctl.rf_we;
    assign wb_sel   = ctl.wb_sel;
    assign cyc      = st_q.cyc;

endmodule

// File: rtl/mcs_ctrl_chk.sv
module mcs_ctrl_chk
    import mcs_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             pc_we,
    input logic             pc_sel,
    input logic [2:0]       alu_op,
    input logic             addr_sel,
    input logic             mem_rd,
    input logic             mem_wr,
    input logic             ir_ld,
    input logic             rf_we,
    input logic             wb_sel,
    input logic [CYC_W-1:0] cyc
);

    AST_FETCH_FROM_PC: assert property (@(posedge clk) disable iff (rst)
        ir_ld |-> (mem_rd && !addr_sel && !mem_wr)); // R6

    AST_FETCH_RESTART: assert property (@(posedge clk) disable iff (rst)
        ir_ld |=> (cyc == '0)); // R9

    AST_CYC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        !ir_ld |=> (cyc == CYC_W'($past(cyc) + 1'b1))); // R9

    AST_FIRST_PC_WRITE: assert property (@(posedge clk) disable iff (rst)
        ir_ld |=> pc_we); // R6

    AST_RF_WRITE_CYC1: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (cyc == CYC_W'(1))); // R2

    AST_STORE_SHAPE: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (cyc == CYC_W'(1) && addr_sel && !rf_we)); // R3

    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R3

    AST_JUMP_FIRST: assert property (@(posedge clk) disable iff (rst)
        (pc_we && pc_sel) |-> (cyc == '0 && !rf_we && !mem_wr)); // R5

    AST_MEM_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
        (rf_we && wb_sel) |-> (mem_rd && alu_op == 3'd0)); // R4

endmodule

bind mcs_ctrl mcs_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .pc_we    (pc_we),
    .pc_sel   (pc_sel),
    .alu_op   (alu_op),
    .addr_sel (addr_sel),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .ir_ld    (ir_ld),
    .rf_we    (rf_we),
    .wb_sel   (wb_sel),
    .cyc      (cyc)
);

// File: tb/tb_mcs_ctrl.sv
`timescale 1ns/100ps
module tb_mcs_ctrl;
    import mcs_pkg::*;

    localparam int MAXI = 256;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [OP_W-1:0]  mem_op;
    logic             pc_we, pc_sel, addr_sel, mem_rd, mem_wr, ir_ld, rf_we, wb_sel;
    logic [2:0]       alu_op;
    logic [CYC_W-1:0] cyc;

    mcs_ctrl dut (
        .clk(clk), .rst(rst), .mem_op(mem_op),
        .pc_we(pc_we), .pc_sel(pc_sel), .alu_op(alu_op), .addr_sel(addr_sel),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_ld(ir_ld), .rf_we(rf_we),
        .wb_sel(wb_sel), .cyc(cyc)
    );

    // ---------------- datapath and memory stub ----------------
    logic [15:0] prog [256];
    logic [15:0] mem  [256];
    logic [15:0] rf   [32];
    logic [15:0] ir, rd_val, rs_val, alu_res, rdata;
    logic [7:0]  pc, addr;

    always_comb begin
        rd_val = rf[ir[9:5]];
        rs_val = rf[ir[4:0]];
        addr   = addr_sel ? rs_val[7:0] : pc;
        rdata  = mem[addr];
        mem_op = rdata[15:10];
        case (alu_op)
            3'd0:    alu_res = {8'h00, pc} + 16'd1;
            3'd1:    alu_res = rd_val + rs_val;
            3'd2:    alu_res = rd_val - rs_val;
            3'd3:    alu_res = rd_val & rs_val;
            3'd4:    alu_res = rd_val | rs_val;
            3'd5:    alu_res = rd_val ^ rs_val;
            3'd6:    alu_res = rs_val;
            default: alu_res = 16'h0000;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= 8'h00;
            ir <= 16'h0000;
            for (int i = 0; i < 32; i++) rf[i] <= 16'h0000;
            for (int i = 0; i < 256; i++) mem[i] <= prog[i];
        end else begin
            if (pc_we)  pc <= pc_sel ? rs_val[7:0] : alu_res[7:0];
            if (ir_ld)  ir <= rdata;
            if (rf_we)  rf[ir[9:5]] <= wb_sel ? rdata : alu_res;
            if (mem_wr) mem[addr] <= rd_val;
        end
    end

    // ---------------- bench bookkeeping ----------------
    int total = 0;
    int bad   = 0;
    bit wd_hit = 1'b0;
    int pp;
    int halt;
    int n_exp;
    logic [15:0] mm  [256];
    logic [15:0] mrf [32];
    int          exp_pc  [MAXI+1];
    logic [5:0]  exp_op  [MAXI];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(input logic [5:0] op, input int rd, input int rs);
        return {op, 5'(rd), 5'(rs)};
    endfunction

    function automatic bit is_alu(input logic [5:0] op);
        return (op >= 6'h01) && (op <= 6'h06);
    endfunction

    function automatic bit is_legal(input logic [5:0] op);
        return is_alu(op) || op == OP_LDI || op == OP_LD || op == OP_ST || op == OP_JMP;
    endfunction

    function automatic int len_of(input logic [5:0] op);
        return (op == OP_LDI || op == OP_LD || op == OP_ST) ? 3 : 2;
    endfunction

    function automatic string req_of(input logic [5:0] op);
        if (is_alu(op)) return "R2";
        if (op == OP_LDI) return "R4";
        if (op == OP_LD || op == OP_ST) return "R3";
        if (op == OP_JMP) return "R5";
        return "R7";
    endfunction

    // {pc_we,pc_sel,alu_op,addr_sel,mem_rd,mem_wr,ir_ld,rf_we,wb_sel}
    function automatic logic [10:0] exp_ctl(input logic [5:0] op, input int c);
        logic pw = 0, ps = 0, asel = 0, mr = 0, mw = 0, il = 0, rw = 0, ws = 0;
        logic [2:0] ao = 3'd0;
        if (c == len_of(op) - 1) begin mr = 1; il = 1; end
        if (c == 0) begin
            pw = 1;
            ps = (op == OP_JMP);
        end else if (c == 1) begin
            if (is_alu(op)) begin rw = 1; ao = op[2:0]; end
            else if (op == OP_LDI) begin mr = 1; rw = 1; ws = 1; pw = 1; end
            else if (op == OP_LD) begin mr = 1; asel = 1; rw = 1; ws = 1; end
            else if (op == OP_ST) begin mw = 1; asel = 1; end
        end
        return {pw, ps, ao, asel, mr, mw, il, rw, ws};
    endfunction

    task automatic emit(input logic [15:0] w);
        prog[pp] = w;
        pp++;
    endtask

    task automatic emit_ldi(input int rd, input logic [15:0] imm);
        emit(enc(OP_LDI, rd, 0));
        emit(imm);
    endtask

    task automatic build_prog();
        int ch, r1, r2, t;
        logic [5:0] op;
        for (int i = 0; i < 256; i++) prog[i] = 16'h0000;
        pp = 0;
        // directed prologue
        emit_ldi(0, 16'h1234);
        emit_ldi(1, 16'h00FF);
        emit_ldi(2, {OP_ST, 10'h005});    // data word that looks like a store (R4)
        emit_ldi(3, {OP_JMP, 10'h001});   // data word that looks like a jump (R4)
        emit(enc(OP_ADD, 0, 1));
        emit(enc(OP_SUB, 0, 2));
        emit(enc(OP_AND, 3, 0));
        emit(enc(OP_OR,  4, 0));
        emit(enc(OP_XOR, 1, 3));
        emit(enc(OP_MOV, 5, 0));
        emit(enc(6'h21, 0, 1));           // near-miss opcodes (R8)
        emit(enc(6'h30, 1, 2));
        emit(enc(6'h07, 2, 3));
        emit(enc(6'h3F, 3, 4));
        emit_ldi(6, 16'd200);
        emit(enc(OP_ST, 0, 6));
        emit(enc(OP_LD, 4, 6));
        emit_ldi(6, 16'd201);
        emit(enc(OP_ST, 5, 6));
        t = pp + 5;
        emit_ldi(7, 16'(t));
        emit(enc(OP_JMP, 0, 7));
        emit(enc(OP_ST, 0, 6));           // skipped by the jump (R5)
        emit(enc(OP_LDI, 0, 0));
        // seeded random body
        for (int i = 0; i < 25; i++) begin
            ch = int'($urandom % 8);
            r1 = int'($urandom % 6);
            r2 = int'($urandom % 6);
            case (ch)
                0, 1, 2: begin
                    op = 6'(1 + $urandom % 6);
                    emit(enc(op, r1, r2));
                end
                3: emit_ldi(r1, 16'($urandom));
                4: begin
                    emit_ldi(6, 16'(200 + $urandom % 32));
                    emit(enc(OP_ST, r1, 6));
                end
                5: emit(enc(OP_LD, r1, 6));
                6: begin
                    op = 6'($urandom % 64);
                    if (is_legal(op)) op = 6'h3E;
                    emit(enc(op, r1, r2));
                end
                default: begin
                    t = pp + 5;
                    emit_ldi(7, 16'(t));
                    emit(enc(OP_JMP, 0, 7));
                    emit(16'($urandom));
                    emit(16'($urandom));
                end
            endcase
        end
        halt = pp + 2;
        emit_ldi(7, 16'(halt));
        emit(enc(OP_JMP, 0, 7));
    endtask

    task automatic run_model();
        int mpc, k;
        logic [15:0] w;
        logic [5:0] op;
        int rd, rs;
        for (int i = 0; i < 256; i++) mm[i] = prog[i];
        for (int i = 0; i < 32; i++) mrf[i] = 16'h0000;
        mpc = 0;
        k = 0;
        while (mpc != halt && k < MAXI) begin
            w  = mm[mpc];
            op = w[15:10];
            rd = int'(w[9:5]);
            rs = int'(w[4:0]);
            exp_pc[k] = mpc;
            exp_op[k] = op;
            case (op)
                OP_ADD: begin mrf[rd] = mrf[rd] + mrf[rs]; mpc = (mpc + 1) & 255; end
                OP_SUB: begin mrf[rd] = mrf[rd] - mrf[rs]; mpc = (mpc + 1) & 255; end
                OP_AND: begin mrf[rd] = mrf[rd] & mrf[rs]; mpc = (mpc + 1) & 255; end
                OP_OR:  begin mrf[rd] = mrf[rd] | mrf[rs]; mpc = (mpc + 1) & 255; end
                OP_XOR: begin mrf[rd] = mrf[rd] ^ mrf[rs]; mpc = (mpc + 1) & 255; end
                OP_MOV: begin mrf[rd] = mrf[rs]; mpc = (mpc + 1) & 255; end
                OP_LDI: begin mrf[rd] = mm[(mpc + 1) & 255]; mpc = (mpc + 2) & 255; end
                OP_LD:  begin mrf[rd] = mm[mrf[rs][7:0]]; mpc = (mpc + 1) & 255; end
                OP_ST:  begin mm[mrf[rs][7:0]] = mrf[rd]; mpc = (mpc + 1) & 255; end
                OP_JMP: mpc = int'(mrf[rs][7:0]);
                default: mpc = (mpc + 1) & 255;
            endcase
            k++;
        end
        exp_pc[k] = mpc;
        n_exp = k;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        wd_hit = 1'b1;
    end

    initial begin
        int k, cnt;
        logic [10:0] got;
        void'($urandom(32'd20240611));
        build_prog();
        run_model();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0.5;
        // boot cycle (R1)
        got = {pc_we, pc_sel, alu_op, addr_sel, mem_rd, mem_wr, ir_ld, rf_we, wb_sel};
        check(got == 11'b0_0_000_0_1_0_1_0_0, "R1", "boot strobes", int'(got), 11'b00000010100);
        check(cyc == '0, "R1", "boot cycle index", int'(cyc), 0);
        check(pc == 8'h00, "R1", "boot fetch address", int'(pc), 0);
        k = 0;
        cnt = 0;
        while (k < n_exp && !wd_hit) begin
            @(negedge clk);
            cnt++;
            got = {pc_we, pc_sel, alu_op, addr_sel, mem_rd, mem_wr, ir_ld, rf_we, wb_sel};
            check(got == exp_ctl(exp_op[k], cnt - 1), req_of(exp_op[k]), "cycle strobes",
                  int'(got), int'(exp_ctl(exp_op[k], cnt - 1)));
            check(int'(cyc) == cnt - 1, "R9", "cycle index", int'(cyc), cnt - 1);
            if (ir_ld) begin
                check(cnt == len_of(exp_op[k]), req_of(exp_op[k]), "instruction length",
                      cnt, len_of(exp_op[k]));
                check(int'(pc) == exp_pc[k + 1], (exp_op[k] == OP_JMP) ? "R5" : "R6",
                      "next fetch address", int'(pc), exp_pc[k + 1]);
                k++;
                cnt = 0;
            end else if (cnt >= 4) begin
                check(1'b0, "R9", "instruction overrun", cnt, 3);
                break;
            end
        end
        repeat (2) @(negedge clk);
        for (int i = 0; i < 8; i++)
            check(rf[i] == mrf[i], "R2", "final register", int'(rf[i]), int'(mrf[i]));
        for (int i = 200; i < 232; i++)
            check(mem[i] == mm[i], "R3", "final data word", int'(mem[i]), int'(mm[i]));
        if (wd_hit) check(1'b0, "R9", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule